// File: doc/BRIEF.md
# Word-Parallel Frame Acquisition Correlator

This block finds the start of a frame in the hard-decided sample stream of one polarization. Each clock it takes one word of in-phase chips and one word of quadrature chips. It searches every bit offset inside a word and every quarter-turn phase rotation at once for a known training sequence. When the match is strong enough, it locks to the winning offset and rotation. From the next word onward it re-aligns the stream to the transmitter's word boundaries, undoes the rotation and emits one clean word pair per clock. It also despreads the signalling field that follows the training into a header word.

Correlation does not search all four rotations separately. One agreement count per channel and per offset is enough, and all four rotation scores follow from those counts by simple arithmetic. The block stays locked until the surrounding frame logic raises `frame_end`. That returns it to search.

Top module: `frame_acq_correlator`

## Requirements
- R1: While `rst` is high at a clock edge, `locked`, `data_valid` and `hdr_valid` are low after that edge.
- R2: The training is L = 64 chips long, sent on both channels alike, so I = Q = c. The chips c[n] come from a 7-bit register that starts at all ones. At each step it outputs its bit 6 and shifts left, taking bit6 XOR bit5 into bit 0. The score of a hypothesis is the number of chip agreements, over both channels, between the de-rotated received chips and c. The block locks only when the best score is above 2L−8 = 120. So 7 chip errors in the training still lock, and 8 errors do not.
- R3: Chip order inside a word is bit 0 first. `lock_off` reports the position, within its word, of the first training chip. `locked` rises at the edge that comes REF_WORDS+1 = 3 edges after the edge that samples the word holding that first chip.
- R4: `lock_rot` reports the rotation that was applied to the transmitted pair (I,Q). The codes are 0 for (I,Q), 1 for (~Q,I), 2 for (~I,~Q) and 3 for (Q,~I).
- R5: While locked, `data_valid` is high and one word pair is emitted per clock. The words start with the chip right after the training, have the rotation undone, and use bit j for the j-th chip of the word.
- R6: The first 32 emitted words each carry one header bit, spread over the 32 I chips of the word. A 1 is sent as the code 32'hB3A51C7E and a 0 as its complement. A bit decodes as 1 exactly when at least 17 of its I chips agree with the code. Header bit k goes to `hdr_word[k]`. `hdr_valid` pulses for one cycle, together with the 32nd emitted word.
- R7: While locked, a later training pattern in the stream changes neither `lock_off` nor `lock_rot`, and emission continues undisturbed.
- R8: After an edge that samples `frame_end` high, `locked` and `data_valid` are low and the block searches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_i | input | 32 | In-phase chips of this clock, bit 0 first |
| in_q | input | 32 | Quadrature chips of this clock, bit 0 first |
| frame_end | input | 1 | Leave the lock and return to search |
| locked | output | 1 | Training found, stream is being aligned |
| lock_rot | output | 2 | Detected rotation code |
| lock_off | output | 5 | Detected chip offset within a word |
| data_valid | output | 1 | data_i / data_q hold an aligned word |
| data_i | output | 32 | Aligned, de-rotated in-phase word |
| data_q | output | 32 | Aligned, de-rotated quadrature word |
| hdr_valid | output | 1 | One-cycle pulse: hdr_word is complete |
| hdr_word | output | 32 | Despread header bits, bit k is the k-th |

## Verification
Frames are built with a random prefix length, which covers many word offsets, and with each of the four rotations, so a wrong offset or a wrong rotation mapping shows up in the reported lock and in the emitted words. Training chips corrupted by exactly 7 and exactly 8 errors test the threshold edge from both sides. A header with 15 and with 16 corrupted chips in single bits probes the majority boundary. A second, shifted training inside the payload shows whether detections are ignored while locked, and the `frame_end` pulse before each frame checks the return to search.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int WORD_W    = 32;
    localparam int REF_WORDS = 2;
    localparam int HDR_BITS  = 32;
    localparam int MAX_REF   = 1024;

    localparam int REF_LEN   = WORD_W * REF_WORDS;
    localparam int WIN_LEN   = WORD_W * (REF_WORDS + 1);
    localparam int OFF_W     = $clog2(WORD_W);
    localparam int SCORE_W   = $clog2(2 * REF_LEN + 1);
    localparam int HCNT_W    = $clog2(HDR_BITS + 1);
    localparam int THRESH_DEF = 2 * REF_LEN - 8;

    localparam logic [WORD_W-1:0] HDR_CODE = 32'hB3A5_1C7E;

    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } rot_e;

    typedef struct packed {
        logic [WORD_W-1:0] i;
        logic [WORD_W-1:0] q;
    } iq_t;

    typedef struct packed {
        logic [SCORE_W-1:0] score;
        rot_e               rot;
        logic [OFF_W-1:0]   off;
    } cand_t;

    // maximal-length chip sequence, chip n at bit n
    function automatic logic [MAX_REF-1:0] train_seq();
        logic [MAX_REF-1:0] seq;
        logic [6:0] st;
        seq = '0;
        st  = 7'h7F;
        for (int n = 0; n < MAX_REF; n++) begin
            seq[n] = st[6];
            st     = {st[5:0], st[6] ^ st[5]};
        end
        return seq;
    endfunction

    localparam logic [MAX_REF-1:0] TRAIN_ALL = train_seq();
    localparam logic [REF_LEN-1:0] TRAIN     = TRAIN_ALL[REF_LEN-1:0];

    // undo a received quarter-turn rotation
    function automatic iq_t derotate(rot_e r, logic [WORD_W-1:0] ri, logic [WORD_W-1:0] rq);
        iq_t o;
        case (r)
            ROT_0:   begin o.i = ri;  o.q = rq;  end
            ROT_90:  begin o.i = rq;  o.q = ~ri; end
            ROT_180: begin o.i = ~ri; o.q = ~rq; end
            default: begin o.i = ~rq; o.q = ri;  end
        endcase
        return o;
    endfunction

    function automatic logic [SCORE_W-1:0] ones_ref(logic [REF_LEN-1:0] x);
        logic [SCORE_W-1:0] c;
        c = '0;
        for (int k = 0; k < REF_LEN; k++) c = c + SCORE_W'(x[k]);
        return c;
    endfunction

    function automatic logic [OFF_W:0] ones_word(logic [WORD_W-1:0] x);
        logic [OFF_W:0] c;
        c = '0;
        for (int k = 0; k < WORD_W; k++) c = c + (OFF_W+1)'(x[k]);
        return c;
    endfunction

endpackage

// File: rtl/acq_window.sv
module acq_window
    import acq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  in_i,
    input  logic [WORD_W-1:0]  in_q,
    output logic [WIN_LEN-1:0] win_i,
    output logic [WIN_LEN-1:0] win_q
);
    // low index = oldest chip
    always_ff @(posedge clk) begin
        if (rst) begin
            win_i <= '0;
            win_q <= '0;
        end else begin
            win_i <= {in_i, win_i[WIN_LEN-1:WORD_W]};
            win_q <= {in_q, win_q[WIN_LEN-1:WORD_W]};
        end
    end
endmodule

// File: rtl/acq_score.sv
module acq_score
    import acq_pkg::*;
(
    input  logic [REF_LEN+WORD_W-2:0] seg_i,
    input  logic [REF_LEN+WORD_W-2:0] seg_q,
    output logic [SCORE_W-1:0]        agr_i [WORD_W],
    output logic [SCORE_W-1:0]        agr_q [WORD_W]
);
    for (genvar o = 0; o < WORD_W; o++) begin : g_off
        assign agr_i[o] = ones_ref(~(seg_i[o +: REF_LEN] ^ TRAIN));
        assign agr_q[o] = ones_ref(~(seg_q[o +: REF_LEN] ^ TRAIN));
    end
endmodule

// File: rtl/acq_pick.sv
module acq_pick
    import acq_pkg::*;
#(
    parameter int THRESH = THRESH_DEF
) (
    input  logic [SCORE_W-1:0] agr_i [WORD_W],
    input  logic [SCORE_W-1:0] agr_q [WORD_W],
    output logic               hit,
    output rot_e               hit_rot,
    output logic [OFF_W-1:0]   hit_off
);
    localparam logic [SCORE_W-1:0] LEN_S = SCORE_W'(REF_LEN);
    localparam logic [SCORE_W-1:0] THR_S = SCORE_W'(THRESH);

    cand_t best;

    // strict compare: ties keep lowest rotation, then lowest offset
    always_comb begin
        logic [SCORE_W-1:0] sc;
        best = '0;
        for (int r = 0; r < 4; r++) begin
            for (int o = 0; o < WORD_W; o++) begin
                case (r)
                    0:       sc = agr_i[o] + agr_q[o];
                    1:       sc = (LEN_S - agr_i[o]) + agr_q[o];
                    2:       sc = (LEN_S - agr_i[o]) + (LEN_S - agr_q[o]);
                    default: sc = agr_i[o] + (LEN_S - agr_q[o]);
                endcase
                if (sc > best.score) begin
                    best.score = sc;
                    best.rot   = rot_e'(r[1:0]);
                    best.off   = o[OFF_W-1:0];
                end
            end
        end
    end

    assign hit     = best.score > THR_S;
    assign hit_rot = best.rot;
    assign hit_off = best.off;
endmodule

// File: rtl/acq_despread.sv
module acq_despread
    import acq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  rot_e                rot,
    input  logic [OFF_W-1:0]    off,
    input  logic [2*WORD_W-1:0] top_i,
    input  logic [2*WORD_W-1:0] top_q,
    output logic                data_valid,
    output logic [WORD_W-1:0]   data_i,
    output logic [WORD_W-1:0]   data_q,
    output logic                hdr_valid,
    output logic [HDR_BITS-1:0] hdr_word
);
    logic [WORD_W-1:0] al_i, al_q;
    iq_t               fix;
    logic [OFF_W:0]    agree;
    logic              hbit;
    logic [HCNT_W-1:0] hcnt;

    always_comb begin
        al_i  = top_i[int'(off) +: WORD_W];
        al_q  = top_q[int'(off) +: WORD_W];
        fix   = derotate(rot, al_i, al_q);
        agree = ones_word(~(fix.i ^ HDR_CODE));
        hbit  = agree > (OFF_W+1)'(WORD_W / 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_valid <= 1'b0;
            data_i     <= '0;
            data_q     <= '0;
            hdr_valid  <= 1'b0;
            hdr_word   <= '0;
            hcnt       <= '0;
        end else begin
            data_valid <= active;
            hdr_valid  <= 1'b0;
            if (active) begin
                data_i <= fix.i;
                data_q <= fix.q;
                if (hcnt < HCNT_W'(HDR_BITS)) begin
                    hdr_word <= (hdr_word & ~(HDR_BITS'(1) << hcnt))
                              | (HDR_BITS'(hbit) << hcnt);
                    hcnt     <= hcnt + 1'b1;
                    if (hcnt == HCNT_W'(HDR_BITS - 1)) hdr_valid <= 1'b1;
                end
            end else begin
                hcnt <= '0;
            end
        end
    end
endmodule

// File: rtl/frame_acq_correlator.sv
module frame_acq_correlator
    import acq_pkg::*;
#(
    parameter int THRESH = THRESH_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WORD_W-1:0]   in_i,
    input  logic [WORD_W-1:0]   in_q,
    input  logic                frame_end,
    output logic                locked,
    output logic [1:0]          lock_rot,
    output logic [OFF_W-1:0]    lock_off,
    output logic                data_valid,
    output logic [WORD_W-1:0]   data_i,
    output logic [WORD_W-1:0]   data_q,
    output logic                hdr_valid,
    output logic [HDR_BITS-1:0] hdr_word
);
    localparam int TOP_BASE = (REF_WORDS - 1) * WORD_W;

    logic [WIN_LEN-1:0] win_i, win_q;
    logic [SCORE_W-1:0] agr_i [WORD_W];
    logic [SCORE_W-1:0] agr_q [WORD_W];
    logic               hit;
    rot_e               hit_rot, rot_q;
    logic [OFF_W-1:0]   hit_off;
    logic               active;

    acq_window u_win (
        .clk(clk), .rst(rst), .in_i(in_i), .in_q(in_q),
        .win_i(win_i), .win_q(win_q)
    );

    acq_score u_score (
        .seg_i(win_i[REF_LEN+WORD_W-2:0]),
        .seg_q(win_q[REF_LEN+WORD_W-2:0]),
        .agr_i(agr_i), .agr_q(agr_q)
    );

    acq_pick #(.THRESH(THRESH)) u_pick (
        .agr_i(agr_i), .agr_q(agr_q),
        .hit(hit), .hit_rot(hit_rot), .hit_off(hit_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            rot_q    <= ROT_0;
            lock_off <= '0;
        end else if (frame_end) begin
            locked <= 1'b0;
        end else if (!locked && hit) begin
            locked   <= 1'b1;
            rot_q    <= hit_rot;
            lock_off <= hit_off;
        end
    end

    assign lock_rot = rot_q;
    assign active   = locked && !frame_end;

    acq_despread u_desp (
        .clk(clk), .rst(rst), .active(active), .rot(rot_q), .off(lock_off),
        .top_i(win_i[WIN_LEN-1:TOP_BASE]), .top_q(win_q[WIN_LEN-1:TOP_BASE]),
        .data_valid(data_valid), .data_i(data_i), .data_q(data_q),
        .hdr_valid(hdr_valid), .hdr_word(hdr_word)
    );
endmodule

// File: rtl/frame_acq_correlator_chk.sv
module frame_acq_correlator_chk
    import acq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frame_end,
    input logic       locked,
    input logic [1:0] lock_rot,
    input logic [OFF_W-1:0] lock_off,
    input logic       data_valid,
    input logic       hdr_valid
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!locked && !data_valid && !hdr_valid));

    p_data_needs_lock_r5: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> locked);

    p_hdr_in_data_r6: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> data_valid);

    p_hdr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> !hdr_valid);

    p_lock_held_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && !frame_end) |=> (locked && $stable(lock_rot) && $stable(lock_off)));

    p_end_unlocks_r8: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (!locked && !data_valid));
endmodule

bind frame_acq_correlator frame_acq_correlator_chk u_chk (
    .clk(clk), .rst(rst), .frame_end(frame_end), .locked(locked),
    .lock_rot(lock_rot), .lock_off(lock_off),
    .data_valid(data_valid), .hdr_valid(hdr_valid)
);

// File: tb/frame_acq_correlator_test.sv
module frame_acq_correlator_test;
    import acq_pkg::*;

    localparam int W   = 32;
    localparam int L   = 64;
    localparam int R   = 2;
    localparam int HB  = 32;
    localparam int NW  = 128;
    localparam int NCH = NW * W;
    localparam logic [31:0] CODE = 32'hB3A5_1C7E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_i = '0, in_q = '0;
    logic        frame_end = 1'b0;
    logic        locked, data_valid, hdr_valid;
    logic [1:0]  lock_rot;
    logic [4:0]  lock_off;
    logic [31:0] data_i, data_q, hdr_word;

    always #2 clk = ~clk;

    frame_acq_correlator uut (
        .clk(clk), .rst(rst), .in_i(in_i), .in_q(in_q), .frame_end(frame_end),
        .locked(locked), .lock_rot(lock_rot), .lock_off(lock_off),
        .data_valid(data_valid), .data_i(data_i), .data_q(data_q),
        .hdr_valid(hdr_valid), .hdr_word(hdr_word)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit txi [NCH];
    bit txq [NCH];
    bit rxi [NCH];
    bit rxq [NCH];
    bit tseq [L];
    logic [31:0] hdr_bits, hdr_exp;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    task automatic gen_train();
        logic [6:0] st;
        st = 7'h7F;
        for (int n = 0; n < L; n++) begin
            tseq[n] = st[6];
            st = {st[5:0], st[6] ^ st[5]};
        end
    endtask

    // build one frame: prefix, training, header, payload; then rotate
    task automatic build(input int rot, input int p, input int terr, input int emb);
        for (int c = 0; c < NCH; c++) begin
            txi[c] = 1'($urandom);
            txq[c] = 1'($urandom);
        end
        for (int k = 0; k < L; k++) begin
            txi[p+k] = tseq[k] ^ (k < terr);
            txq[p+k] = tseq[k];
        end
        hdr_bits = $urandom;
        for (int b = 0; b < HB; b++) begin
            int agree;
            agree = 0;
            for (int j = 0; j < W; j++) begin
                bit chip;
                int idx;
                idx  = p + L + b * W + j;
                chip = hdr_bits[b] ? CODE[j] : ~CODE[j];
                txq[idx] = chip;
                txi[idx] = chip ^ (((b == 3) && (j < 15)) || ((b == 5) && (j < 16)));
                if (txi[idx] == CODE[j]) agree++;
            end
            hdr_exp[b] = (agree >= 17);
        end
        if (emb > 0) begin
            for (int k = 0; k < L; k++) begin
                txi[emb+k] = tseq[k];
                txq[emb+k] = tseq[k];
            end
        end
        for (int c = 0; c < NCH; c++) begin
            case (rot)
                0:       begin rxi[c] = txi[c];  rxq[c] = txq[c];  end
                1:       begin rxi[c] = ~txq[c]; rxq[c] = txi[c];  end
                2:       begin rxi[c] = ~txi[c]; rxq[c] = ~txq[c]; end
                default: begin rxi[c] = txq[c];  rxq[c] = ~txi[c]; end
            endcase
        end
    endtask

    task automatic run_frame(input int rot, input int p, input bit exp_lock, input bit emb);
        int first, k, bad, hdr_at;
        bit hdr_seen;
        logic [31:0] hdr_got;
        first = -1; k = 0; bad = 0; hdr_seen = 0; hdr_at = -1; hdr_got = '0;
        @(negedge clk);
        frame_end = 1'b1;
        in_i = $urandom;
        in_q = $urandom;
        for (int n = 0; n < NW; n++) begin
            @(negedge clk);
            if (n == 0) begin
                chk(!locked && !data_valid, "R8", "lock after frame_end",
                    {locked, data_valid}, 0);
                frame_end = 1'b0;
            end else begin
                if (locked && first < 0) first = n;
                if (data_valid) begin
                    for (int j = 0; j < W; j++) begin
                        int idx;
                        idx = p + L + k * W + j;
                        if (idx < NCH)
                            if (data_i[j] != txi[idx] || data_q[j] != txq[idx]) bad++;
                    end
                    k++;
                end
                if (hdr_valid) begin
                    hdr_seen = 1;
                    hdr_at   = k;
                    hdr_got  = hdr_word;
                end
            end
            for (int j = 0; j < W; j++) begin
                in_i[j] = rxi[n*W + j];
                in_q[j] = rxq[n*W + j];
            end
        end
        if (exp_lock) begin
            chk(first >= 0, "R2", "training detected", first, (p / W) + R + 2);
            chk(first == (p / W) + R + 2, "R3", "lock cycle", first, (p / W) + R + 2);
            chk(lock_off == 5'(p % W), emb ? "R7" : "R3", "lock_off", lock_off, p % W);
            chk(lock_rot == 2'(rot), emb ? "R7" : "R4", "lock_rot", lock_rot, rot);
            chk(bad == 0 && k > 40, "R5", "aligned word mismatches", bad, 0);
            chk(hdr_seen && hdr_at == HB, "R6", "hdr_valid position", hdr_at, HB);
            chk(hdr_got == hdr_exp, "R6", "hdr_word", hdr_got, hdr_exp);
        end else begin
            chk(first < 0 && k == 0, "R2", "no lock below threshold", first, -1);
        end
    endtask

    initial begin
        int p;
        void'($urandom(32'd4711));
        gen_train();
        repeat (4) @(negedge clk);
        chk(!locked && !data_valid && !hdr_valid, "R1", "outputs in reset",
            {locked, data_valid, hdr_valid}, 0);
        rst = 1'b0;

        p = 100 + int'($urandom % 200);
        build(0, p, 0, 0);
        run_frame(0, p, 1'b1, 1'b0);

        p = 100 + int'($urandom % 200);
        build(1, p, 7, 0);
        run_frame(1, p, 1'b1, 1'b0);

        p = 100 + int'($urandom % 200);
        build(2, p, 8, 0);
        run_frame(2, p, 1'b0, 1'b0);

        p = 100 + int'($urandom % 200);
        build(3, p, 0, p + L + HB * W + 165);
        run_frame(3, p, 1'b1, 1'b1);

        for (int f = 0; f < 4; f++) begin
            int rr;
            rr = int'($urandom % 4);
            p  = 96 + f * 37 + int'($urandom % 64);
            build(rr, p, int'($urandom % 4), 0);
            run_frame(rr, p, 1'b1, 1'b0);
        end

        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        chk(!locked && !data_valid, "R8", "final frame_end", {locked, data_valid}, 0);
        frame_end = 1'b0;
        summary();
    end
endmodule